// File: doc/BRIEF.md
# Used Ring Completion and Interrupt Gate

This block retires finished requests of one virtual queue. A put command stores a completion record, made of the head descriptor index and the number of bytes produced, into the next slot of the used ring in guest memory. It then advances a private completion counter. The counter stays invisible to the driver until a separate sync command writes it into the ring's index field. Several completions can therefore be batched behind a single index update.

After publishing, the block decides whether the driver is interrupted. The driver can ask for silence through a flag in the available ring. That request is overridden when the negotiated feature set asks for a notification on an empty queue and the queue has in fact drained. A raised interrupt sets the queue cause bit in an 8-bit cause register and drives a level interrupt line. Reading the cause register clears both. Raised and suppressed decisions are each counted. Two further commands set or clear the device's own "do not notify me" bit in the used ring flags word by read-modify-write, leaving the other flag bits untouched.

The used ring layout is fixed in little-endian byte offsets from `ring_base`:
- offset 0: 16-bit flags word.
- offset 2: 16-bit index.
- offset 4 onward: 8-byte records, each a 32-bit id followed by a 32-bit length.

The memory port is 32 bits wide with byte enables. Read data returns on a later cycle flagged by `mem_rvalid`.

Top module: `used_ring_retire`

## Requirements
- R1: After reset, and for as long as reset is held: `cmd_ready`=1, `irq`=0, `isr_q`=0, both counters are 0, `mem_req`=0, and the completion counter is 0, so the next sync publishes index 0.
- R2: A put (`cmd_op`=0) issues exactly two word writes with byte enables 4'b1111 in consecutive cycles. The first writes `cmd_id` at `ring_base`+4+8·slot. The second writes `cmd_len` at `ring_base`+8+8·slot.
- R3: The slot is the completion counter modulo 2^QSIZE_LOG2. Each put increments the 16-bit counter by one, and the counter wraps modulo 65536. After 2^QSIZE_LOG2 puts, slot 0 is reused.
- R4: A sync (`cmd_op`=1) writes the counter to byte offset 2, as the upper half of the word at `ring_base` with byte enables 4'b1100. The flags half is left unchanged.
- R5: When a sync completes with `avail_no_intr`=0, `isr_q` bit 0 and `irq` are set and `raised_cnt` increments by one. All of this is visible one cycle after the write cycle.
- R6: When a sync completes with `avail_no_intr`=1, and either `notify_on_empty`=0 or `avail_idx`≠`next_avail`, then `irq` and `isr_q` are unchanged and `skipped_cnt` increments by one.
- R7: When a sync completes with `avail_no_intr`=1, `notify_on_empty`=1 and `avail_idx`=`next_avail`, the interrupt is raised as in R5.
- R8: A cycle with `isr_rd`=1 clears `isr_q` and lowers `irq`. If a raise falls in the same cycle, the raise wins: `isr_q` ends at 8'h01 and `irq` stays 1.
- R9: Commands 2 and 3 read the word at `ring_base`. They then write it back with byte enables 4'b0011, with bit 0 cleared for command 2 (notifications enabled) or set for command 3 (notifications suppressed). All other flag bits are preserved. The write happens only after the read data has returned.
- R10: `cmd_ready` is 0 from the acceptance of a command until it completes: 2 cycles for put, 1 for sync, read, wait and write-back for flags commands. `cmd_valid` while `cmd_ready`=0 is ignored and writes no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is 1 |
| cmd_op | input | 2 | 0 put, 1 sync, 2 enable notify, 3 suppress notify |
| cmd_id | input | 32 | Head descriptor index for put |
| cmd_len | input | 32 | Byte count for put |
| cmd_ready | output | 1 | Block idle, command will be accepted |
| ring_base | input | AW | Byte address of the used ring, 8-byte aligned |
| avail_no_intr | input | 1 | Driver's interrupt-suppression flag from the available ring |
| notify_on_empty | input | 1 | Negotiated notify-on-empty feature |
| avail_idx | input | 16 | Driver's available index |
| next_avail | input | 16 | Device's next available index to consume |
| isr_rd | input | 1 | Cause register read, clears it |
| isr_q | output | 8 | Interrupt cause register, bit 0 is queue cause |
| irq | output | 1 | Level interrupt line |
| raised_cnt | output | CNT_W | Interrupts raised |
| skipped_cnt | output | CNT_W | Interrupts suppressed |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The collision of interest is a cause register read landing in the exact cycle in which a sync decides to raise. The bench sets up a pending cause first, so that a plain clear and a winning raise give different results. It then holds `isr_rd` in the cycle after the sync is accepted, which is the decision cycle. Afterwards it expects `isr_q`=8'h01, `irq`=1 and one more raised count. A lost raise would show as zero. A clear that fails to act would leave no difference, so the cause register is first cleared and re-raised on its own, where a stuck bit is visible.

// File: rtl/used_ring_retire.sv
module used_ring_retire #(
  parameter int AW = 16,
  parameter int QSIZE_LOG2 = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [31:0]      cmd_id,
  input  logic [31:0]      cmd_len,
  output logic             cmd_ready,
  input  logic [AW-1:0]    ring_base,
  input  logic             avail_no_intr,
  input  logic             notify_on_empty,
  input  logic [15:0]      avail_idx,
  input  logic [15:0]      next_avail,
  input  logic             isr_rd,
  output logic [7:0]       isr_q,
  output logic             irq,
  output logic [CNT_W-1:0] raised_cnt,
  output logic [CNT_W-1:0] skipped_cnt,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_rvalid
);

  localparam logic [1:0] OP_PUT    = 2'd0;
  localparam logic [1:0] OP_SYNC   = 2'd1;
  localparam logic [1:0] OP_NTF_ON = 2'd2;
  localparam logic [7:0] CAUSE_Q   = 8'h01;

  typedef enum logic [2:0] {S_IDLE, S_ID, S_LEN, S_PUB, S_RD, S_WAIT, S_WB} st_t;

  st_t                   st;
  logic [1:0]            op_q;
  logic [31:0]           id_q, len_q, flg_q;
  logic [15:0]           used_q;
  logic [QSIZE_LOG2-1:0] slot;
  logic [AW-1:0]         elem;
  logic                  take, gate_open, fire, skip;

  assign take      = cmd_valid && (st == S_IDLE);
  assign gate_open = !avail_no_intr || (notify_on_empty && (avail_idx == next_avail));
  assign fire      = (st == S_PUB) && gate_open;
  assign skip      = (st == S_PUB) && !gate_open;
  assign slot      = used_q[QSIZE_LOG2-1:0];
  assign elem      = ring_base + AW'(4) + AW'({slot, 3'b000});
  assign cmd_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_PUT;
      id_q   <= '0;
      len_q  <= '0;
      flg_q  <= '0;
      used_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          op_q  <= cmd_op;
          id_q  <= cmd_id;
          len_q <= cmd_len;
          case (cmd_op)
            OP_PUT:  st <= S_ID;
            OP_SYNC: st <= S_PUB;
            default: st <= S_RD;
          endcase
        end
        S_ID:  st <= S_LEN;
        S_LEN: begin
          used_q <= used_q + 16'd1;
          st     <= S_IDLE;
        end
        S_PUB: st <= S_IDLE;
        S_RD:  st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          flg_q <= (op_q == OP_NTF_ON) ? (mem_rdata & ~32'h1) : (mem_rdata | 32'h1);
          st    <= S_WB;
        end
        S_WB:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q       <= '0;
      irq         <= 1'b0;
      raised_cnt  <= '0;
      skipped_cnt <= '0;
    end else begin
      if (fire) begin
        isr_q      <= (isr_rd ? 8'h00 : isr_q) | CAUSE_Q;
        irq        <= 1'b1;
        raised_cnt <= raised_cnt + CNT_W'(1);
      end else if (isr_rd) begin
        isr_q <= '0;
        irq   <= 1'b0;
      end
      if (skip)
        skipped_cnt <= skipped_cnt + CNT_W'(1);
    end
  end

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b1;
    mem_addr  = ring_base;
    mem_be    = 4'b0000;
    mem_wdata = 32'h0;
    case (st)
      S_ID:  begin mem_addr = elem;          mem_be = 4'b1111; mem_wdata = id_q;  end
      S_LEN: begin mem_addr = elem + AW'(4); mem_be = 4'b1111; mem_wdata = len_q; end
      S_PUB: begin mem_be = 4'b1100; mem_wdata = {used_q, 16'h0000}; end
      S_RD:  begin mem_we = 1'b0; mem_be = 4'b0011; end
      S_WB:  begin mem_be = 4'b0011; mem_wdata = flg_q; end
      default: begin mem_req = 1'b0; mem_we = 1'b0; end
    endcase
  end

endmodule

// File: rtl/used_ring_retire_chk.sv
module used_ring_retire_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             irq,
  input logic [7:0]       isr_q,
  input logic [CNT_W-1:0] raised_cnt,
  input logic [CNT_W-1:0] skipped_cnt,
  input logic             mem_req,
  input logic             mem_we,
  input logic [3:0]       mem_be,
  input logic             mem_rvalid
);

  assert_busy_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmd_ready);

  assert_be_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != 4'b0000));

  assert_irq_tracks_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == isr_q[0]);

  assert_irq_rise_at_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(!cmd_ready));

  assert_raise_sets_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raised_cnt != $past(raised_cnt)) |-> isr_q[0]);

  assert_skip_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (skipped_cnt != $past(skipped_cnt)) |-> (skipped_cnt == $past(skipped_cnt) + CNT_W'(1)));

  assert_flag_write_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (mem_be == 4'b0011)) |-> $past(mem_rvalid));

endmodule

bind used_ring_retire used_ring_retire_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .irq(irq), .isr_q(isr_q),
  .raised_cnt(raised_cnt), .skipped_cnt(skipped_cnt), .mem_req(mem_req),
  .mem_we(mem_we), .mem_be(mem_be), .mem_rvalid(mem_rvalid)
);

// File: tb/used_ring_retire_tb_top.sv
module used_ring_retire_tb_top;
  localparam int AW = 16;
  localparam int CNT_W = 16;
  localparam int WBASE = 16;
  localparam logic [3:0] VEC [0:6] = '{4'b0001, 4'b0111, 4'b1000, 4'b1010,
                                       4'b1100, 4'b1111, 4'b0011};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [31:0] cmd_id = '0, cmd_len = '0;
  logic [AW-1:0] ring_base = 16'h0040;
  logic avail_no_intr = 1'b1, notify_on_empty = 1'b0;
  logic [15:0] avail_idx = 16'h1235, next_avail = 16'h1234;
  logic isr_rd = 1'b0, irq;
  logic [7:0] isr_q;
  logic [CNT_W-1:0] raised_cnt, skipped_cnt;
  logic mem_req, mem_we, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [31:0] mem [0:63];
  logic tb_wr = 1'b0;
  logic [5:0] tb_idx = '0;
  logic [31:0] tb_dat = '0;
  int checks = 0, fails = 0, exp_rs = 0, exp_sk = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  used_ring_retire #(.AW(AW), .QSIZE_LOG2(3), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_len(cmd_len), .cmd_ready(cmd_ready),
    .ring_base(ring_base), .avail_no_intr(avail_no_intr),
    .notify_on_empty(notify_on_empty), .avail_idx(avail_idx),
    .next_avail(next_avail), .isr_rd(isr_rd), .isr_q(isr_q), .irq(irq),
    .raised_cnt(raised_cnt), .skipped_cnt(skipped_cnt), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid));

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (tb_wr) mem[tb_idx] <= tb_dat;
    else if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end else if (mem_req) begin
      mem_rdata  <= mem[mem_addr[7:2]];
      mem_rvalid <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] id, input logic [31:0] len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_len = len;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic poke(input int idx, input logic [31:0] d);
    @(negedge clk);
    tb_wr = 1'b1; tb_idx = 6'(idx); tb_dat = d;
    @(negedge clk);
    tb_wr = 1'b0;
  endtask

  task automatic read_isr();
    @(negedge clk); isr_rd = 1'b1;
    @(negedge clk); isr_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(cmd_ready), 32'd1);
    chk("R1 irq in reset", 32'(irq), 32'd0);
    chk("R1 isr in reset", 32'(isr_q), 32'd0);
    chk("R1 raised in reset", 32'(raised_cnt), 32'd0);
    chk("R1 skipped in reset", 32'(skipped_cnt), 32'd0);
    chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();

    for (int k = 0; k < 10; k++) begin
      issue(2'd0, 32'd100 + 32'(k), 32'h1000 + 32'(k));
      chk("R2 id word", mem[WBASE + 1 + 2*(k%8)], 32'd100 + 32'(k));
      chk("R2 len word", mem[WBASE + 2 + 2*(k%8)], 32'h1000 + 32'(k));
    end
    chk("R3 slot 0 reused", mem[WBASE + 1], 32'd108);
    chk("R3 slot 7 kept", mem[WBASE + 15], 32'd107);

    poke(WBASE, 32'h0000_A5A4);
    avail_no_intr = 1'b1; notify_on_empty = 1'b0;
    issue(2'd1, '0, '0);
    exp_sk++;
    chk("R4 index published, flags kept", mem[WBASE], 32'h000A_A5A4);
    chk("R6 skip counted", 32'(skipped_cnt), 32'(exp_sk));
    chk("R6 irq unchanged", 32'(irq), 32'd0);

    for (int v = 0; v < 7; v++) begin
      avail_no_intr   = VEC[v][3];
      notify_on_empty = VEC[v][2];
      avail_idx       = VEC[v][1] ? 16'h1234 : 16'h1235;
      read_isr();
      issue(2'd1, '0, '0);
      if (VEC[v][0]) exp_rs++; else exp_sk++;
      chk("R5 R6 R7 irq decision", 32'(irq), 32'(VEC[v][0]));
      chk("R5 R7 cause bit", 32'(isr_q), VEC[v][0] ? 32'h1 : 32'h0);
      chk("R5 raised count", 32'(raised_cnt), 32'(exp_rs));
      chk("R6 skipped count", 32'(skipped_cnt), 32'(exp_sk));
    end

    read_isr();
    chk("R8 read clears isr", 32'(isr_q), 32'd0);
    chk("R8 read lowers irq", 32'(irq), 32'd0);

    avail_no_intr = 1'b0;
    issue(2'd1, '0, '0);
    exp_rs++;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0; isr_rd = 1'b1;
    @(negedge clk);
    isr_rd = 1'b0;
    exp_rs++;
    chk("R8 raise wins over clear isr", 32'(isr_q), 32'h1);
    chk("R8 raise wins over clear irq", 32'(irq), 32'd1);
    chk("R8 raise counted", 32'(raised_cnt), 32'(exp_rs));

    issue(2'd3, '0, '0);
    chk("R9 suppress sets bit0", mem[WBASE], 32'h000A_A5A5);
    issue(2'd3, '0, '0);
    chk("R9 suppress idempotent", mem[WBASE], 32'h000A_A5A5);

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2;
    @(negedge clk);
    cmd_op = 2'd0; cmd_id = 32'hDEAD; cmd_len = 32'hBEEF;
    chk("R10 ready low while busy", 32'(cmd_ready), 32'd0);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    chk("R9 enable clears bit0", mem[WBASE], 32'h000A_A5A4);
    chk("R10 busy put ignored", mem[WBASE + 5], 32'd102);
    avail_no_intr = 1'b1; notify_on_empty = 1'b0;
    issue(2'd1, '0, '0);
    exp_sk++;
    chk("R10 counter not advanced", mem[WBASE], 32'h000A_A5A4);

    do_reset();
    issue(2'd1, '0, '0);
    chk("R1 counter zero after reset", mem[WBASE], 32'h0000_A5A4);
    chk("R1 skip after reset", 32'(skipped_cnt), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule